// File: doc/BRIEF.md
# Framed serial register-write receiver

This block takes 32-bit configuration writes from a serial data line. A transfer opens when an active-low frame sync line is seen low on a falling edge of the serial clock, after having been seen high on the edge before. From the next falling edge on, the block takes one data bit per falling edge, most significant bit first, until 32 bits have arrived.

The upper half of the word carries a 3-bit target device field and an 8-bit register address. The lower half carries the register data. Several receivers can share one serial bus, each with a different strapped device number. Only the receiver whose number matches the device field issues a one-clock write strobe. The strobe comes with the register address and the data. The register file that consumes the strobe is outside this block.

Top module: `cfgw_frame_rx`

## Requirements
- R1: A synchronous active-high reset, sampled on a falling edge, returns the block to idle and clears `wr_stb`, `wr_reg` and `wr_data` to zero. It also clears the sync history, so a frame can only start after `frm_n` has been sampled high at least once following reset. A reset in the middle of a frame abandons that frame.
- R2: A frame starts at a falling edge where `frm_n` is sampled low and was sampled high at the previous falling edge. The first data bit is taken from `sdi` at the next falling edge.
- R3: A frame is exactly 32 bits, sent most significant bit first. The word is laid out as follows: bits 31:29 hold the target device number, bits 28:24 are reserved and ignored, bits 23:16 hold the register address, and bits 15:0 hold the data.
- R4: When the device field equals `dev_id`, `wr_stb` goes high at the falling edge that takes the 32nd bit and stays high for exactly one clock period. During that period `wr_reg` and `wr_data` show the frame's address and data.
- R5: When the device field differs from `dev_id`, no strobe is issued and `wr_reg` and `wr_data` keep their previous values.
- R6: The sync pulse may stay low for any width from 1 to 32 clock periods without changing the received word.
- R7: Falling edges of `frm_n` that occur while the 32 bits are being received are ignored. They neither restart nor shorten the frame.
- R8: When a frame completes while `frm_n` is still low, no further frame starts until `frm_n` has been sampled high and then low again.
- R9: Frames may run back to back. If `frm_n` is sampled high at the 32nd-bit edge and low at the next edge, the next frame starts at that next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock. All state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| frm_n | input | 1 | Frame sync, active low |
| sdi | input | 1 | Serial data, MSB first |
| dev_id | input | 3 | Strapped device number of this receiver |
| wr_stb | output | 1 | One-clock register-write strobe |
| wr_reg | output | 8 | Register address of the last accepted write |
| wr_data | output | 16 | Data of the last accepted write |

## Verification
If the bit counter or the shift register slips by one position, the device field lands on the wrong bits. This shows up either as a missing or extra strobe, or as shifted `wr_reg`/`wr_data` values, in the very clock period that ends the frame. If the sync history is wrong, a frame starts one edge early or late, or restarts mid-frame. Glitch, held-low and back-to-back patterns expose this within one frame length, because the per-cycle reference comparison flags the strobe in the wrong period.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int DEV_W  = 3;
    localparam int REG_W  = 8;
    localparam int RSV_W  = HALF_W - DEV_W - REG_W;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } rx_state_e;

    // Received word, MSB first on the wire.
    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [RSV_W-1:0]  rsv;
        logic [REG_W-1:0]  addr;
        logic [HALF_W-1:0] data;
    } wr_cmd_t;

    function automatic wr_cmd_t split_word(input logic [WORD_W-1:0] w);
        return wr_cmd_t'(w);
    endfunction

endpackage

// File: rtl/cfgw_sync_det.sv
module cfgw_sync_det
    import cfgw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frm_n,
    output logic fall
);

    // Level of frame sync at the previous falling edge; cleared by reset so a
    // line held low across reset cannot open a frame.
    logic seen_high;

    always_ff @(negedge clk) begin
        if (rst) begin
            seen_high <= 1'b0;
        end else begin
            seen_high <= frm_n;
        end
    end

    assign fall = seen_high & ~frm_n;

endmodule

// File: rtl/cfgw_shifter.sv
module cfgw_shifter
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sdi,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-2:0] sr;

    assign busy = (st == ST_SHIFT);
    assign done = busy && (cnt == LAST_BIT);
    assign word = {sr, sdi};

    always_ff @(negedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            sr  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_SHIFT;
                        cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    sr <= {sr[WORD_W-3:0], sdi};
                    if (done) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: a fresh sync fall in idle opens a frame at the next edge
    p_start_opens_r2: assert property (@(negedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R7: once receiving, nothing but the 32nd bit ends the frame
    p_ignore_resync_r7: assert property (@(negedge clk) disable iff (rst)
        (busy && !done) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

    // R3: the frame closes right after the last bit
    p_frame_len_r3: assert property (@(negedge clk) disable iff (rst)
        done |=> (!busy && cnt == '0));

endmodule

// File: rtl/cfgw_addr_match.sv
module cfgw_addr_match
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic [DEV_W-1:0]  dev_id,
    output logic              wr_stb,
    output logic [REG_W-1:0]  wr_reg,
    output logic [HALF_W-1:0] wr_data
);

    wr_cmd_t cmd;
    logic    hit;
    logic    unused_rsv;

    assign cmd        = split_word(word);
    assign hit        = done && (cmd.dev == dev_id);
    assign unused_rsv = ^cmd.rsv;

    always_ff @(negedge clk) begin
        if (rst) begin
            wr_stb  <= 1'b0;
            wr_reg  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= hit;
            if (hit) begin
                wr_reg  <= cmd.addr;
                wr_data <= cmd.data;
            end
        end
    end

    // R4: the strobe lasts one clock period
    p_stb_single_r4: assert property (@(negedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R4: a strobe only follows a completed frame
    p_stb_after_frame_r4: assert property (@(negedge clk) disable iff (rst)
        wr_stb |-> $past(done));

    // R5: address and data hold whenever no strobe is issued
    p_hold_on_miss_r5: assert property (@(negedge clk) disable iff (rst)
        !wr_stb |-> ($stable(wr_reg) && $stable(wr_data)));

endmodule

// File: rtl/cfgw_frame_rx.sv
module cfgw_frame_rx
    import cfgw_pkg::*;
(
    input  logic              sclk,
    input  logic              rst,
    input  logic              frm_n,
    input  logic              sdi,
    input  logic [DEV_W-1:0]  dev_id,
    output logic              wr_stb,
    output logic [REG_W-1:0]  wr_reg,
    output logic [HALF_W-1:0] wr_data
);

    logic              sync_fall;
    logic              rx_busy;
    logic              rx_done;
    logic [WORD_W-1:0] rx_word;

    cfgw_sync_det u_sync (
        .clk   (sclk),
        .rst   (rst),
        .frm_n (frm_n),
        .fall  (sync_fall)
    );

    cfgw_shifter u_shift (
        .clk   (sclk),
        .rst   (rst),
        .start (sync_fall),
        .sdi   (sdi),
        .busy  (rx_busy),
        .done  (rx_done),
        .word  (rx_word)
    );

    cfgw_addr_match u_match (
        .clk     (sclk),
        .rst     (rst),
        .done    (rx_done),
        .word    (rx_word),
        .dev_id  (dev_id),
        .wr_stb  (wr_stb),
        .wr_reg  (wr_reg),
        .wr_data (wr_data)
    );

    // R8: a line held low after a frame never reopens one
    p_no_restart_low_r8: assert property (@(negedge sclk) disable iff (rst)
        (!rx_busy && !frm_n && $past(!frm_n)) |=> !rx_busy);

endmodule

// File: tb/cfgw_frame_rx_tb_top.sv
`timescale 1ns/1ps
module cfgw_frame_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_n = 1'b0;
    logic        sdi = 1'b0;
    logic [2:0]  dev_id = 3'd5;
    logic        wr_stb;
    logic [7:0]  wr_reg;
    logic [15:0] wr_data;

    int    checks = 0;
    int    errors = 0;
    int    n_stb = 0;
    int    cycles = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    cfgw_frame_rx dut_i (
        .sclk    (clk),
        .rst     (rst),
        .frm_n   (frm_n),
        .sdi     (sdi),
        .dev_id  (dev_id),
        .wr_stb  (wr_stb),
        .wr_reg  (wr_reg),
        .wr_data (wr_data)
    );

    // Behavioural reference: bit queue filled after a fresh sync fall.
    logic        e_stb = 1'b0;
    logic [7:0]  e_reg = '0;
    logic [15:0] e_data = '0;
    bit          m_prev = 1'b0;
    bit          m_busy = 1'b0;
    logic        q[$];

    always @(negedge clk) begin
        logic [31:0] w;
        if (rst) begin
            m_prev = 1'b0; m_busy = 1'b0; q.delete();
            e_stb = 1'b0; e_reg = '0; e_data = '0;
        end else begin
            e_stb = 1'b0;
            if (m_busy) begin
                q.push_back(sdi);
                if (q.size() == 32) begin
                    for (int k = 0; k < 32; k++) w[31-k] = q[k];
                    if (w[31:29] == dev_id) begin
                        e_stb = 1'b1; e_reg = w[23:16]; e_data = w[15:0];
                    end
                    m_busy = 1'b0;
                    q.delete();
                end
            end else if (m_prev && !frm_n) begin
                m_busy = 1'b1;
            end
            m_prev = frm_n;
        end
    end

    task automatic cmp();
        checks++;
        if (wr_stb !== e_stb || wr_reg !== e_reg || wr_data !== e_data) begin
            errors++;
            $display("FAIL %s cycle compare actual %0b/%h/%h expected %0b/%h/%h",
                     tag, wr_stb, wr_reg, wr_data, e_stb, e_reg, e_data);
        end
        if (wr_stb === 1'b1) n_stb++;
    endtask

    task automatic step(input logic f, input logic d);
        @(posedge clk);
        cmp();
        frm_n = f;
        sdi   = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic check_cnt(input string t, input int exp);
        checks++;
        if (n_stb != exp) begin
            errors++;
            $display("FAIL %s strobe count actual %0d expected %0d", t, n_stb, exp);
        end
        n_stb = 0;
    endtask

    task automatic check_out(input string t, input logic [7:0] r, input logic [15:0] d);
        @(posedge clk);
        checks++;
        if (wr_stb !== 1'b0 || wr_reg !== r || wr_data !== d) begin
            errors++;
            $display("FAIL %s outputs actual %0b/%h/%h expected 0/%h/%h",
                     t, wr_stb, wr_reg, wr_data, r, d);
        end
    endtask

    // lowlen: periods frm_n stays low counting the start edge; glitch: low pulse at that bit index
    task automatic send_frame(input logic [31:0] w, input int lowlen, input int glitch);
        step(1'b0, 1'b0);
        for (int i = 31; i >= 0; i--) begin
            int  j;
            logic f;
            j = 32 - i;
            f = (j < lowlen) ? 1'b0 : 1'b1;
            if (glitch > 0 && (j == glitch || j == glitch + 1)) f = 1'b0;
            step(f, w[i]);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with sync held low
        tag = "R1";
        step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b1);
        check_out("R1", 8'h00, 16'h0000);
        rst = 1'b0;
        // R8: line low out of reset must not open a frame
        tag = "R8";
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
        idle(2);
        check_cnt("R8", 0);

        tag = "R4";
        send_frame({3'd5, 5'h15, 8'h3C, 16'hA55A}, 1, 0);
        idle(2);
        check_cnt("R4", 1);
        check_out("R3", 8'h3C, 16'hA55A);

        tag = "R5";
        send_frame({3'd2, 5'h00, 8'h77, 16'h1111}, 4, 0);
        idle(2);
        check_cnt("R5", 0);
        check_out("R5", 8'h3C, 16'hA55A);

        tag = "R6";
        send_frame({3'd5, 5'h00, 8'hF0, 16'h1234}, 32, 0);
        idle(2);
        check_cnt("R6", 1);
        check_out("R6", 8'hF0, 16'h1234);

        tag = "R7";
        send_frame({3'd5, 5'h0A, 8'h81, 16'hBEEF}, 1, 10);
        idle(2);
        check_cnt("R7", 1);
        check_out("R7", 8'h81, 16'hBEEF);

        tag = "R8";
        send_frame({3'd5, 5'h00, 8'h42, 16'h5A5A}, 40, 0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
        check_cnt("R8", 1);
        idle(1);
        send_frame({3'd5, 5'h00, 8'h43, 16'h6B6B}, 2, 0);
        idle(2);
        check_cnt("R8", 1);
        check_out("R8", 8'h43, 16'h6B6B);

        tag = "R9";
        send_frame({3'd5, 5'h00, 8'h10, 16'hC001}, 1, 0);
        send_frame({3'd5, 5'h00, 8'h11, 16'hC002}, 1, 0);
        idle(2);
        check_cnt("R9", 2);
        check_out("R9", 8'h11, 16'hC002);

        // R2 and R3 with another strap: reserved bits set, device 7 rejected
        tag = "R3";
        dev_id = 3'd0;
        idle(1);
        send_frame({3'd0, 5'h1F, 8'h00, 16'hFFFF}, 3, 0);
        send_frame({3'd7, 5'h1F, 8'h99, 16'h0F0F}, 1, 0);
        idle(2);
        check_cnt("R3", 1);
        check_out("R2", 8'h00, 16'hFFFF);

        // R1: reset in the middle of a frame
        tag = "R1";
        step(1'b0, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
        rst = 1'b1;
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        rst = 1'b0;
        check_out("R1", 8'h00, 16'h0000);
        idle(2);
        send_frame({3'd0, 5'h00, 8'hA0, 16'h0A0A}, 1, 0);
        idle(2);
        check_cnt("R1", 1);
        check_out("R1", 8'hA0, 16'h0A0A);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule